// File: doc/BRIEF.md
# Audio Master Clock Divider

This block produces the serial-port bit clock and frame clock of an audio interface when the device is the clock master and takes its master clock directly from an external pin, with no on-chip PLL in the path. A two-bit code selects how many master-clock cycles make up one sample period: 256, 512 or 1024. A second two-bit code selects 32 or 64 bit-clock periods per frame. The frame clock runs at the sample rate. Both clocks have a 50% duty cycle, and the frame clock changes only on a falling edge of the bit clock.

The clocks run only when the master/slave control selects master and the PLL enable is off. The block raises an invalid-configuration flag for a reserved bit-clock code, for a frame-clock format bit of 1, and for the DSP-style interface format. Configuration changes made while the divider runs take effect only at the next frame boundary.

A second clock domain runs from a free-running reference clock and holds a watchdog that notices when the master clock stops. While the master clock is absent, the converter and filter power requests are forced off.

Top module: `acd_master_clkgen`

## Requirements
- R1: `bclk`, `fclk` and `out_en` can be high only while `master_sel`=1 and `pll_en`=0. If either condition is removed, `out_en`, `bclk` and `fclk` are all low after the next `mclk` rising edge.
- R2: `ratio_sel[1:0]` sets the frame length in `mclk` cycles: 00 gives 256, 01 gives 1024, 10 gives 512 and 11 gives 256. The `fclk` period equals this frame length, and `ratio_sel[3:2]` has no effect.
- R3: `bclk_sel` 01 makes the `bclk` period equal to the frame length divided by 32. `bclk_sel` 10 makes it the frame length divided by 64.
- R4: In master mode (`master_sel`=1, `pll_en`=0), `bclk_sel` 00 or 11 sets `cfg_invalid`=1 and holds `out_en`, `bclk` and `fclk` low. Outside master mode, `cfg_invalid` is 0.
- R5: In master mode, `fck_fmt`=1 or `if_fmt`=00 (the DSP format) sets `cfg_invalid`=1 and holds the outputs low. Any other `if_fmt` value with `fck_fmt`=0 and a valid `bclk_sel` runs the clocks.
- R6: `bclk` and `fclk` each have a 50% duty cycle. While `out_en` stays high, every change of `fclk` happens on the same `mclk` edge as a falling edge of `bclk`.
- R7: When the outputs start, `out_en` rises with `bclk` and `fclk` low. `fclk` then rises exactly half a frame length of `mclk` cycles later.
- R8: If `ratio_sel` or `bclk_sel` changes to another valid value while the clocks run, the current frame completes with the old setting, and the new setting starts at the next frame boundary.
- R9: `clk_absent` rises after `mclk` has been idle for between WD_TIMEOUT and WD_TIMEOUT+6 `ref_clk` cycles (16 by default). It clears within 12 `ref_clk` cycles after `mclk` resumes.
- R10: `adc_run`, `dac_run` and `pfil_run` follow `pwr_adc`, `pwr_dac` and `pwr_pfil` while `clk_absent`=0. All three are 0 while `clk_absent`=1.
- R11: During reset, `out_en`, `bclk` and `fclk` are 0 and `clk_absent` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | External master clock; clocks the divider |
| ref_clk | input | 1 | Free-running reference clock for the watchdog |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| pll_en | input | 1 | PLL enable control; must be 0 for this block to run |
| master_sel | input | 1 | 1 selects clock-master operation |
| ratio_sel | input | 4 | Master-clock-to-sample-rate code; only bits 1:0 are decoded |
| bclk_sel | input | 2 | Bit-clock rate code |
| fck_fmt | input | 1 | Frame-clock format bit; must be 0 |
| if_fmt | input | 2 | Audio interface format; 00 is the DSP format |
| pwr_adc | input | 1 | ADC power request |
| pwr_dac | input | 1 | DAC power request |
| pwr_pfil | input | 1 | Programmable-filter power request |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock at the sample rate |
| out_en | output | 1 | Clock outputs are being driven |
| cfg_invalid | output | 1 | Master mode with an unsupported configuration |
| clk_absent | output | 1 | Master clock currently missing |
| adc_run | output | 1 | Gated ADC power enable |
| dac_run | output | 1 | Gated DAC power enable |
| pfil_run | output | 1 | Gated programmable-filter power enable |

## Verification
The properties assume that the mode, format and rate inputs change synchronously to `mclk` and are steady around its rising edge. They also assume that the power requests do not race `ref_clk`, and that `mclk` has no glitches when it stops or resumes. The stimulus changes every control input at a falling edge of `mclk`, or while `mclk` is stopped. It stops and restarts `mclk` only with the clock level low, so every edge the design sees is a full-width one.

// File: rtl/acd_pkg.sv
package acd_pkg;

  // Interface format code that selects the unsupported DSP-style framing.
  localparam logic [1:0] FMT_DSP = 2'b00;

  // Active configuration: ratio code and bit-clock code.
  typedef struct packed {
    logic [1:0] ratio;
    logic [1:0] bsel;
  } acd_cfg_t;

  // log2 of the frame length in master-clock cycles.
  function automatic logic [3:0] ratio_log2(input logic [1:0] code);
    case (code)
      2'b01:   return 4'd10;
      2'b10:   return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic bclk_code_ok(input logic [1:0] code);
    return (code == 2'b01) || (code == 2'b10);
  endfunction

  // log2 of the bit-clock periods per frame.
  function automatic logic [3:0] bclk_log2(input logic [1:0] code);
    return (code == 2'b10) ? 4'd6 : 4'd5;
  endfunction

  // Counter bit that forms the bit clock: half its period in master-clock cycles.
  function automatic logic [3:0] bclk_tap(input acd_cfg_t c);
    return ratio_log2(c.ratio) - bclk_log2(c.bsel) - 4'd1;
  endfunction

  // Counter bit that forms the frame clock.
  function automatic logic [3:0] fclk_tap(input acd_cfg_t c);
    return ratio_log2(c.ratio) - 4'd1;
  endfunction

endpackage

// File: rtl/acd_cfg_decode.sv
module acd_cfg_decode
  import acd_pkg::*;
(
  input  logic       pll_en,
  input  logic       master_sel,
  input  logic [3:0] ratio_sel,
  input  logic [1:0] bclk_sel,
  input  logic       fck_fmt,
  input  logic [1:0] if_fmt,
  output logic       mode_ok,
  output logic       cfg_bad,
  output logic       go,
  output acd_cfg_t   cfg
);

  // Upper ratio bits carry no meaning in this mode.
  logic unused_ratio_hi;
  assign unused_ratio_hi = ^ratio_sel[3:2];

  assign mode_ok   = master_sel && !pll_en;
  assign cfg_bad   = !bclk_code_ok(bclk_sel) || fck_fmt || (if_fmt == FMT_DSP);
  assign go        = mode_ok && !cfg_bad;
  assign cfg.ratio = ratio_sel[1:0];
  assign cfg.bsel  = bclk_sel;

endmodule

// File: rtl/acd_frame_div.sv
module acd_frame_div
  import acd_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic     mclk,
  input  logic     rst_n,
  input  logic     go,
  input  acd_cfg_t cfg_in,
  output logic     bclk,
  output logic     fclk,
  output logic     out_en,
  output logic     frame_wrap,
  output acd_cfg_t act_cfg
);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, lim;
  logic             run_q, run_nxt;
  acd_cfg_t         cfg_q, cfg_nxt;
  logic             bclk_q, fclk_q;

  assign lim        = CNT_W'((32'd1 << ratio_log2(cfg_q.ratio)) - 32'd1);
  assign frame_wrap = run_q && (cnt_q == lim);

  always_comb begin
    run_nxt = run_q;
    cnt_nxt = cnt_q;
    cfg_nxt = cfg_q;
    if (!go) begin
      run_nxt = 1'b0;
      cnt_nxt = '0;
      cfg_nxt = cfg_in;
    end else if (!run_q || frame_wrap) begin
      run_nxt = 1'b1;
      cnt_nxt = '0;
      cfg_nxt = cfg_in;
    end else begin
      cnt_nxt = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      cfg_q  <= '0;
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
    end else begin
      run_q  <= run_nxt;
      cnt_q  <= cnt_nxt;
      cfg_q  <= cfg_nxt;
      bclk_q <= run_nxt && cnt_nxt[bclk_tap(cfg_nxt)];
      fclk_q <= run_nxt && cnt_nxt[fclk_tap(cfg_nxt)];
    end
  end

  assign bclk    = bclk_q;
  assign fclk    = fclk_q;
  assign out_en  = run_q;
  assign act_cfg = cfg_q;

endmodule

// File: rtl/acd_mclk_watch.sv
module acd_mclk_watch #(
  parameter int WD_TIMEOUT  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic mclk,
  input  logic ref_clk,
  input  logic rst_n,
  output logic mclk_seen,
  output logic clk_absent
);

  localparam int WD_W = $clog2(WD_TIMEOUT + 1);

  logic                 tgl_q;
  logic [SYNC_STAGES:0] sync_q;
  logic [WD_W-1:0]      wd_q;
  logic                 absent_q;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= !tgl_q;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], tgl_q};
  end

  assign mclk_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q     <= '0;
      absent_q <= 1'b1;
    end else if (mclk_seen) begin
      wd_q     <= '0;
      absent_q <= 1'b0;
    end else if (wd_q == WD_W'(WD_TIMEOUT - 1)) begin
      absent_q <= 1'b1;
    end else begin
      wd_q <= wd_q + WD_W'(1);
    end
  end

  assign clk_absent = absent_q;

endmodule

// File: rtl/acd_master_clkgen.sv
module acd_master_clkgen
  import acd_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int WD_TIMEOUT  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       mclk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       pll_en,
  input  logic       master_sel,
  input  logic [3:0] ratio_sel,
  input  logic [1:0] bclk_sel,
  input  logic       fck_fmt,
  input  logic [1:0] if_fmt,
  input  logic       pwr_adc,
  input  logic       pwr_dac,
  input  logic       pwr_pfil,
  output logic       bclk,
  output logic       fclk,
  output logic       out_en,
  output logic       cfg_invalid,
  output logic       clk_absent,
  output logic       adc_run,
  output logic       dac_run,
  output logic       pfil_run
);

  logic     mode_ok, cfg_bad, go;
  acd_cfg_t cfg_req, act_cfg;
  logic     frame_wrap, mclk_seen;

  acd_cfg_decode u_dec (
    .pll_en     (pll_en),
    .master_sel (master_sel),
    .ratio_sel  (ratio_sel),
    .bclk_sel   (bclk_sel),
    .fck_fmt    (fck_fmt),
    .if_fmt     (if_fmt),
    .mode_ok    (mode_ok),
    .cfg_bad    (cfg_bad),
    .go         (go),
    .cfg        (cfg_req)
  );

  acd_frame_div #(.CNT_W(CNT_W)) u_div (
    .mclk       (mclk),
    .rst_n      (rst_n),
    .go         (go),
    .cfg_in     (cfg_req),
    .bclk       (bclk),
    .fclk       (fclk),
    .out_en     (out_en),
    .frame_wrap (frame_wrap),
    .act_cfg    (act_cfg)
  );

  acd_mclk_watch #(.WD_TIMEOUT(WD_TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_wd (
    .mclk       (mclk),
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .mclk_seen  (mclk_seen),
    .clk_absent (clk_absent)
  );

  assign cfg_invalid = mode_ok && cfg_bad;
  assign adc_run     = pwr_adc  && !clk_absent;
  assign dac_run     = pwr_dac  && !clk_absent;
  assign pfil_run    = pwr_pfil && !clk_absent;

endmodule

// File: rtl/acd_master_clkgen_chk.sv
module acd_master_clkgen_chk (
  input logic       mclk,
  input logic       ref_clk,
  input logic       rst_n,
  input logic       pll_en,
  input logic       master_sel,
  input logic       cfg_invalid,
  input logic       bclk,
  input logic       fclk,
  input logic       out_en,
  input logic       clk_absent,
  input logic       adc_run,
  input logic       dac_run,
  input logic       pfil_run,
  input logic       frame_wrap,
  input logic [3:0] act_cfg,
  input logic       mclk_seen
);

  // R1
  mode_gate_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !(master_sel && !pll_en) |=> !out_en);

  // R1
  idle_low_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !out_en |-> (!bclk && !fclk));

  // R4
  invalid_stop_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    cfg_invalid |=> !out_en);

  // R6
  fclk_align_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (out_en && $past(out_en) && (fclk != $past(fclk))) |-> ($past(bclk) && !bclk));

  // R8
  cfg_switch_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (out_en && $past(out_en) && (act_cfg != $past(act_cfg))) |-> $past(frame_wrap));

  // R9
  absent_clear_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(clk_absent) |-> $past(mclk_seen));

  // R10
  run_gate_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    clk_absent |-> !(adc_run || dac_run || pfil_run));

endmodule

bind acd_master_clkgen acd_master_clkgen_chk u_chk (
  .mclk        (mclk),
  .ref_clk     (ref_clk),
  .rst_n       (rst_n),
  .pll_en      (pll_en),
  .master_sel  (master_sel),
  .cfg_invalid (cfg_invalid),
  .bclk        (bclk),
  .fclk        (fclk),
  .out_en      (out_en),
  .clk_absent  (clk_absent),
  .adc_run     (adc_run),
  .dac_run     (dac_run),
  .pfil_run    (pfil_run),
  .frame_wrap  (frame_wrap),
  .act_cfg     (act_cfg),
  .mclk_seen   (mclk_seen)
);

// File: tb/tb_acd_master_clkgen.sv
`timescale 1ns/1ps
module tb_acd_master_clkgen;

  localparam int WD = 16;

  logic mclk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0, mclk_run = 1'b1;
  logic pll_en = 1'b0, master_sel = 1'b0, fck_fmt = 1'b0;
  logic [3:0] ratio_sel = 4'd0;
  logic [1:0] bclk_sel = 2'b10, if_fmt = 2'b10;
  logic pwr_adc = 1'b1, pwr_dac = 1'b1, pwr_pfil = 1'b0;
  logic bclk, fclk, out_en, cfg_invalid, clk_absent, adc_run, dac_run, pfil_run;

  int checks = 0, failures = 0, align_err = 0;
  logic pb = 1'b0, pf = 1'b0, pe = 1'b0;

  always begin #5; if (mclk_run) mclk = !mclk; end
  always #7 ref_clk = !ref_clk;

  acd_master_clkgen #(.WD_TIMEOUT(WD)) dut (
    .mclk(mclk), .ref_clk(ref_clk), .rst_n(rst_n), .pll_en(pll_en),
    .master_sel(master_sel), .ratio_sel(ratio_sel), .bclk_sel(bclk_sel),
    .fck_fmt(fck_fmt), .if_fmt(if_fmt), .pwr_adc(pwr_adc), .pwr_dac(pwr_dac),
    .pwr_pfil(pwr_pfil), .bclk(bclk), .fclk(fclk), .out_en(out_en),
    .cfg_invalid(cfg_invalid), .clk_absent(clk_absent), .adc_run(adc_run),
    .dac_run(dac_run), .pfil_run(pfil_run)
  );

  // R6 monitor: a frame-clock change must coincide with a bit-clock fall
  always @(negedge mclk) begin
    if (rst_n && out_en && pe && (fclk != pf) && !(pb && !bclk)) align_err++;
    pb = bclk; pf = fclk; pe = out_en;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int w);
    return (w == 0) ? fclk : (w == 1) ? bclk : out_en;
  endfunction

  task automatic wait_level(input int w, input logic lvl, output int n);
    n = 0;
    do begin @(negedge mclk); n++; end while (sig(w) !== lvl && n < 5000);
  endtask

  task automatic count_active(input int cyc, output int hi);
    hi = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge mclk);
      if (out_en || bclk || fclk) hi++;
    end
  endtask

  function automatic int frame_len(input logic [3:0] r);
    case (r % 4)
      1: return 1024;
      2: return 512;
      default: return 256;
    endcase
  endfunction

  task automatic restart(input logic [3:0] r, input logic [1:0] b);
    int n;
    @(negedge mclk); master_sel = 1'b0;
    repeat (3) @(negedge mclk);
    ratio_sel = r; bclk_sel = b; master_sel = 1'b1;
    wait_level(2, 1'b1, n);
  endtask

  task automatic run_combo(input logic [3:0] r, input logic [1:0] b);
    int n, len, per;
    len = frame_len(r);
    per = len / ((b == 2'b01) ? 32 : 64);
    restart(r, b);
    chk(cfg_invalid == 1'b0, "R4", int'(cfg_invalid), 0);
    wait_level(0, 1'b1, n); chk(n == len / 2, "R7", n, len / 2);
    wait_level(0, 1'b0, n); chk(n == len / 2, "R2", n, len / 2);
    wait_level(0, 1'b1, n); chk(n == len / 2, "R6", n, len / 2);
    wait_level(1, 1'b1, n); chk(n == per / 2, "R3", n, per / 2);
    wait_level(1, 1'b0, n); chk(n == per / 2, "R3", n, per / 2);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    int n, hi;
    repeat (4) @(negedge ref_clk);
    // R11 reset state
    chk(out_en == 0 && bclk == 0 && fclk == 0, "R11", int'({out_en, bclk, fclk}), 0);
    chk(clk_absent == 1'b1, "R11", int'(clk_absent), 1);
    @(negedge mclk); rst_n = 1'b1;

    // R2/R3/R6/R7 sweep over every ratio code (upper bits too) and both rates
    for (int b = 1; b <= 2; b++)
      for (int r = 0; r < 16; r++)
        run_combo(4'(r), 2'(b));
    chk(align_err == 0, "R6", align_err, 0);

    // R1 PLL enabled while running
    @(negedge mclk); pll_en = 1'b1;
    @(negedge mclk);
    chk(out_en == 0 && bclk == 0 && fclk == 0, "R1", int'({out_en, bclk, fclk}), 0);
    count_active(40, hi); chk(hi == 0, "R1", hi, 0);
    chk(cfg_invalid == 1'b0, "R4", int'(cfg_invalid), 0);
    pll_en = 1'b0; master_sel = 1'b0; bclk_sel = 2'b00;
    @(negedge mclk);
    chk(cfg_invalid == 1'b0, "R4", int'(cfg_invalid), 0);
    count_active(40, hi); chk(hi == 0, "R1", hi, 0);

    // R4 reserved bit-clock codes
    for (int c = 0; c < 4; c += 3) begin
      bclk_sel = 2'(c); master_sel = 1'b1;
      @(negedge mclk);
      chk(cfg_invalid == 1'b1, "R4", int'(cfg_invalid), 1);
      count_active(60, hi); chk(hi == 0, "R4", hi, 0);
    end

    // R5 frame-clock format bit and DSP format
    bclk_sel = 2'b10; fck_fmt = 1'b1;
    @(negedge mclk);
    chk(cfg_invalid == 1'b1, "R5", int'(cfg_invalid), 1);
    count_active(60, hi); chk(hi == 0, "R5", hi, 0);
    fck_fmt = 1'b0; if_fmt = 2'b00;
    @(negedge mclk);
    chk(cfg_invalid == 1'b1, "R5", int'(cfg_invalid), 1);
    count_active(60, hi); chk(hi == 0, "R5", hi, 0);
    if_fmt = 2'b01;
    wait_level(2, 1'b1, n);
    chk(out_en == 1'b1 && cfg_invalid == 1'b0, "R5", int'(out_en), 1);

    // R8 ratio change mid-frame takes effect at the boundary
    restart(4'd0, 2'b10);
    wait_level(0, 1'b1, n);
    ratio_sel = 4'd2;
    wait_level(0, 1'b0, n); chk(n == 128, "R8", n, 128);
    wait_level(0, 1'b1, n); chk(n == 256, "R8", n, 256);
    wait_level(1, 1'b1, n); chk(n == 4, "R8", n, 4);

    // R9/R10 master clock loss and recovery
    repeat (4) @(negedge ref_clk);
    chk(adc_run == 1 && dac_run == 1 && pfil_run == 0, "R10", int'({adc_run, dac_run, pfil_run}), 6);
    @(negedge mclk); mclk_run = 1'b0;
    n = 0;
    while (!clk_absent && n < 100) begin @(negedge ref_clk); n++; end
    chk(n >= WD && n <= WD + 6, "R9", n, WD);
    pwr_pfil = 1'b1;
    #1;
    chk(adc_run == 0 && dac_run == 0 && pfil_run == 0, "R10", int'({adc_run, dac_run, pfil_run}), 0);
    mclk_run = 1'b1;
    repeat (12) @(negedge ref_clk);
    chk(clk_absent == 1'b0, "R9", int'(clk_absent), 0);
    chk(adc_run == 1 && dac_run == 1 && pfil_run == 1, "R10", int'({adc_run, dac_run, pfil_run}), 7);

    finish_run();
  end

endmodule